// File: doc/BRIEF.md
# Script Instruction Fetch Sequencer

This block is the front end of a scripts processor that controls a parallel storage bus. After a start pulse it reads two-word instructions from memory at a script pointer. It steps over all-zero words and sorts each instruction into one of four classes. For data-transfer (block-move) instructions it resolves the operand address in one of three ways (direct, indirect, or through a table at a data-structure base). It compares the bus phase the instruction expects with the live phase. It then offers the finished instruction to the executors on a dispatch channel.

A run ends in one of three ways: an interrupt, a stop request, or single-step mode after one instruction. A runaway-loop guard counts fetch attempts per run and forces a disconnect interrupt when a programmable budget is used up.

Two channels use valid/ready with back-pressure:

- **Memory read request channel.** Once `rd_req_valid` is raised, the request and its address stay fixed until `rd_req_ready` is seen. At most one read is outstanding. The response arrives on `rd_rsp_valid` for exactly one cycle, and the sequencer always takes it.
- **Dispatch channel.** Once `disp_valid` is raised, all dispatch fields stay fixed until `disp_ready` is seen.

Top module: `scr_fetch_seq`

## Requirements
- R1: An instruction is a first word read at the script pointer P and a second word read at P+4. After the second word is received, the pointer becomes P+8. At dispatch, `script_ptr` shows the advanced value.
- R2: When a first word reads as 0x00000000, the pointer advances by 4 only, and fetching restarts at the new address. That word still uses one fetch attempt from the budget.
- R3: With `insn_limit` = N, at most N first-word fetch attempts are made per run. At the next attempt, `irq_udc` is raised and the run ends with no further read. N = 0 raises the interrupt before any read. The attempt counter clears on every start that leaves idle.
- R4: The dispatch fields are filled from the two words as follows:
  - `disp_class` is bits 31:30 of the first word: 0 = block move, 1 = I/O or register operation, 2 = transfer control, 3 = memory move or load/store.
  - `disp_cmd` is bits 31:24 of the first word.
  - `disp_aux` is the second word.
  - For any class other than a block move, and for a direct block move, `disp_count` is bits 23:0 of the first word and `disp_addr` is the second word.
- R5: A block move with bit 29 set is indirect. `disp_addr` is the word read at the address held in the second word. Bit 29 takes precedence over bit 28.
- R6: A block move with bit 28 set (and bit 29 clear) is table-indirect. Bits 23:0 of the second word are sign-extended and added to `dsa_base` to give address T. `disp_count` is bits 23:0 of the word at T, and `disp_addr` is the word at T+4.
- R7: A block move whose bits 26:24 differ from `bus_phase` raises `irq_phase` and is not dispatched. `bus_phase` is sampled when the last operand word arrives.
- R8: With `step_en` high, every accepted dispatch is followed by `irq_step` in the next cycle, and the run ends.
- R9: A `stop` pulse during a run takes effect at the next instruction boundary, before a new read is offered. The block returns to idle with no interrupt.
- R10: `rd_req_valid` with its address, and `disp_valid` with its fields, are held unchanged until the matching ready is seen.
- R11: Each interrupt output is a one-cycle pulse, and at most one is high at a time. In the cycle after the pulse, `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run from idle; ignored otherwise |
| stop | input | 1 | Requests an end of the run at the next instruction boundary |
| start_ptr | input | AW | Script pointer loaded on start |
| dsa_base | input | AW | Data-structure base for table-indirect operands |
| insn_limit | input | CW | Fetch-attempt budget per run |
| step_en | input | 1 | Single-step mode |
| bus_phase | input | 3 | Current bus phase |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | AW | Memory read byte address |
| rd_rsp_valid | input | 1 | Read data valid, one cycle per request |
| rd_rsp_data | input | 32 | Read data |
| disp_valid | output | 1 | Dispatch valid |
| disp_ready | input | 1 | Dispatch accepted by executor |
| disp_class | output | 2 | Instruction class |
| disp_cmd | output | 8 | Command byte |
| disp_count | output | 24 | Byte count |
| disp_addr | output | AW | Resolved operand address |
| disp_aux | output | 32 | Raw second word |
| busy | output | 1 | High while a run is active |
| script_ptr | output | AW | Current script pointer |
| irq_udc | output | 1 | Budget-exhausted disconnect interrupt |
| irq_phase | output | 1 | Phase-mismatch interrupt |
| irq_step | output | 1 | Single-step interrupt |

## Verification
The bench tries the fetch path with several kinds of instruction stream:

- **Random streams.** These mix all four classes, block moves in all three addressing modes, scattered zero words, and matching and mismatching phases. They are run under random stalls on the read and dispatch channels. A software walk of the same memory predicts the resolved fields and the ending cause, so the streams show whether the sequencer picks the right addressing mode and the right interrupt.
- **Directed cases.** A budget of zero, and a budget that is used up exactly on a zero word, separate a correct attempt count from one that skips zero words or is off by one. A block move with both mode bits set shows which mode has precedence, and a negative table offset shows that sign extension is done. A long stream stopped mid-run shows that stop leaves no read pending and raises no interrupt.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH0, S_FETCH1, S_INDIR, S_DISP, S_HALT
  } seq_st_t;

  typedef enum logic [1:0] {
    C_NONE, C_UDC, C_PHASE, C_STEP
  } halt_cause_t;

  localparam logic [1:0] CLS_BMOVE = 2'd0;
endpackage

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [31:0]   w0,
  input  logic [31:0]   w1,
  input  logic [AW-1:0] dsa_base,
  output logic          is_bm,
  output logic          mode_ind,
  output logic          mode_tbl,
  output logic [2:0]    want_phase,
  output logic [AW-1:0] tbl_addr
);
  localparam int OFSW = 24;
  logic [AW-1:0] ofs;

  always_comb begin
    is_bm      = (w0[31:30] == CLS_BMOVE);
    mode_ind   = is_bm && w0[29];
    mode_tbl   = is_bm && !w0[29] && w0[28];
    want_phase = w0[26:24];
    ofs        = {{(AW-OFSW){w1[OFSW-1]}}, w1[OFSW-1:0]};
    tbl_addr   = dsa_base + ofs;
  end
endmodule

// File: rtl/scr_budget.sv
module scr_budget #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          exhausted
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign exhausted = (cnt >= limit);

  // R3: an attempt is only ever taken while budget remains
  p_inc_in_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !exhausted);
  // R3: a clear always empties the count
  p_clr_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/scr_fetch_seq.sv
module scr_fetch_seq
  import scr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [AW-1:0] start_ptr,
  input  logic [AW-1:0] dsa_base,
  input  logic [CW-1:0] insn_limit,
  input  logic          step_en,
  input  logic [2:0]    bus_phase,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [31:0]   rd_rsp_data,
  output logic          disp_valid,
  input  logic          disp_ready,
  output logic [1:0]    disp_class,
  output logic [7:0]    disp_cmd,
  output logic [23:0]   disp_count,
  output logic [AW-1:0] disp_addr,
  output logic [31:0]   disp_aux,
  output logic          busy,
  output logic [AW-1:0] script_ptr,
  output logic          irq_udc,
  output logic          irq_phase,
  output logic          irq_step
);
  localparam logic [AW-1:0] WORD_B = AW'(4);
  localparam logic [AW-1:0] INSN_B = AW'(8);

  seq_st_t       st;
  halt_cause_t   cause;
  logic          issued, req_up, stop_pend, tstep;
  logic [AW-1:0] dsp, op_addr;
  logic [31:0]   w0, w1;
  logic [23:0]   op_cnt;
  logic          is_bm, mode_ind, mode_tbl, exh;
  logic [2:0]    want_phase;
  logic [AW-1:0] tbl_addr;
  logic          rsp_take, req_fire;

  scr_decode #(.AW(AW)) u_dec (
    .w0(w0), .w1(w1), .dsa_base(dsa_base),
    .is_bm(is_bm), .mode_ind(mode_ind), .mode_tbl(mode_tbl),
    .want_phase(want_phase), .tbl_addr(tbl_addr)
  );

  scr_budget #(.CW(CW)) u_budget (
    .clk(clk), .rst_n(rst_n),
    .clr(st == S_IDLE && start),
    .inc(req_fire && st == S_FETCH0),
    .limit(insn_limit),
    .exhausted(exh)
  );

  always_comb begin
    rd_req_valid = 1'b0;
    rd_req_addr  = dsp;
    unique case (st)
      S_FETCH0: rd_req_valid = !issued && (req_up || (!stop_pend && !exh));
      S_FETCH1: begin
        rd_req_valid = !issued;
        rd_req_addr  = dsp + WORD_B;
      end
      S_INDIR: begin
        rd_req_valid = !issued;
        if (mode_ind)   rd_req_addr = w1[AW-1:0];
        else if (tstep) rd_req_addr = tbl_addr + WORD_B;
        else            rd_req_addr = tbl_addr;
      end
      default: ;
    endcase
  end

  assign req_fire   = rd_req_valid && rd_req_ready;
  assign rsp_take   = issued && rd_rsp_valid;
  assign disp_valid = (st == S_DISP);
  assign disp_class = w0[31:30];
  assign disp_cmd   = w0[31:24];
  assign disp_count = op_cnt;
  assign disp_addr  = op_addr;
  assign disp_aux   = w1;
  assign busy       = (st != S_IDLE);
  assign script_ptr = dsp;
  assign irq_udc    = (st == S_HALT) && (cause == C_UDC);
  assign irq_phase  = (st == S_HALT) && (cause == C_PHASE);
  assign irq_step   = (st == S_HALT) && (cause == C_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cause     <= C_NONE;
      issued    <= 1'b0;
      req_up    <= 1'b0;
      stop_pend <= 1'b0;
      tstep     <= 1'b0;
      dsp       <= '0;
      op_addr   <= '0;
      op_cnt    <= '0;
      w0        <= '0;
      w1        <= '0;
    end else begin
      req_up <= rd_req_valid && !rd_req_ready;
      if (stop && st != S_IDLE) stop_pend <= 1'b1;
      if (req_fire) issued <= 1'b1;
      unique case (st)
        S_IDLE: if (start) begin
          st        <= S_FETCH0;
          dsp       <= start_ptr;
          stop_pend <= 1'b0;
        end
        S_FETCH0: begin
          if (!issued && !req_up && stop_pend) begin
            st        <= S_IDLE;
            stop_pend <= 1'b0;
          end else if (!issued && !req_up && exh) begin
            st    <= S_HALT;
            cause <= C_UDC;
          end else if (rsp_take) begin
            issued <= 1'b0;
            if (rd_rsp_data == 32'd0) begin
              dsp <= dsp + WORD_B;
            end else begin
              w0 <= rd_rsp_data;
              st <= S_FETCH1;
            end
          end
        end
        S_FETCH1: if (rsp_take) begin
          issued  <= 1'b0;
          w1      <= rd_rsp_data;
          dsp     <= dsp + INSN_B;
          op_cnt  <= w0[23:0];
          op_addr <= rd_rsp_data[AW-1:0];
          tstep   <= 1'b0;
          if (is_bm && (w0[29] || w0[28])) begin
            st <= S_INDIR;
          end else if (is_bm && want_phase != bus_phase) begin
            st    <= S_HALT;
            cause <= C_PHASE;
          end else begin
            st <= S_DISP;
          end
        end
        S_INDIR: if (rsp_take) begin
          issued <= 1'b0;
          if (mode_tbl && !tstep) begin
            op_cnt <= rd_rsp_data[23:0];
            tstep  <= 1'b1;
          end else begin
            op_addr <= rd_rsp_data[AW-1:0];
            if (want_phase != bus_phase) begin
              st    <= S_HALT;
              cause <= C_PHASE;
            end else begin
              st <= S_DISP;
            end
          end
        end
        S_DISP: if (disp_ready) begin
          if (step_en) begin
            st    <= S_HALT;
            cause <= C_STEP;
          end else begin
            st <= S_FETCH0;
          end
        end
        S_HALT: begin
          st    <= S_IDLE;
          cause <= C_NONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: a received second word moves the pointer by a full instruction
  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH1 && rsp_take) |=> (dsp == $past(dsp) + INSN_B));
  // R2: an empty first word moves the pointer by one word only
  p_zero_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH0 && rsp_take && rd_rsp_data == 32'd0) |=> (dsp == $past(dsp) + WORD_B));
  // R8: single step follows every accepted dispatch
  p_step_after_disp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && step_en) |=> irq_step);
  // R10: request held under back-pressure
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R10: dispatch held under back-pressure
  p_disp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_addr) && $stable(disp_count)
                                     && $stable(disp_cmd)));
  // R11: interrupts exclusive, single-cycle, then idle
  p_irq_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_udc, irq_phase, irq_step}));
  p_irq_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_udc || irq_phase || irq_step) |=> (!busy && !irq_udc && !irq_phase && !irq_step));
  // R9: stop never abandons an outstanding read
  p_idle_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!issued && !rd_req_valid));
endmodule

// File: tb/scr_fetch_seq_bench.sv
`timescale 1ns/1ps
module scr_fetch_seq_bench;
  localparam int EV_DISP = 0, EV_UDC = 1, EV_PH = 2, EV_STEP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, step_en = 0;
  logic [31:0] start_ptr = 0, dsa_base = 0;
  logic [15:0] insn_limit = 0;
  logic [2:0]  bus_phase = 0;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0;
  logic [31:0] rd_req_addr, rd_rsp_data = 0;
  logic disp_valid, disp_ready = 0;
  logic [1:0] disp_class;
  logic [7:0] disp_cmd;
  logic [23:0] disp_count;
  logic [31:0] disp_addr, disp_aux, script_ptr;
  logic busy, irq_udc, irq_phase, irq_step;

  int total = 0, bad = 0;
  bit fin = 0;
  logic [31:0] mem [256];
  int m_ptr, m_cnt, m_lim, m_dsa;
  logic [2:0] m_phase;
  int rdy_pct = 70;

  always #2.5 clk = ~clk;

  scr_fetch_seq u_scr_fetch_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .start_ptr(start_ptr),
    .dsa_base(dsa_base), .insn_limit(insn_limit), .step_en(step_en), .bus_phase(bus_phase),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_class(disp_class),
    .disp_cmd(disp_cmd), .disp_count(disp_count), .disp_addr(disp_addr), .disp_aux(disp_aux),
    .busy(busy), .script_ptr(script_ptr),
    .irq_udc(irq_udc), .irq_phase(irq_phase), .irq_step(irq_step));

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model and back-pressure, R10 hold checks
  int pend = 0;
  logic [31:0] pend_data;
  bit pw = 0, dw = 0;
  logic [31:0] pa, pd_addr, pd_aux;
  logic [23:0] pd_cnt;
  always @(negedge clk) begin
    rd_rsp_valid <= 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= pend_data;
      end
    end
    rd_req_ready <= (($urandom % 100) < 60);
    disp_ready   <= (($urandom % 100) < rdy_pct);
    #1;
    if (pw) chk(rd_req_valid && rd_req_addr == pa, "R10", "read request hold", rd_req_addr, pa);
    if (dw) chk(disp_valid && disp_addr == pd_addr && disp_count == pd_cnt && disp_aux == pd_aux,
                "R10", "dispatch hold", disp_addr, pd_addr);
    pw = rd_req_valid && !rd_req_ready;
    pa = rd_req_addr;
    dw = disp_valid && !disp_ready;
    pd_addr = disp_addr; pd_cnt = disp_count; pd_aux = disp_aux;
    if (rd_req_valid && rd_req_ready) begin
      pend = 1 + int'($urandom % 3);
      pend_data = mem[rd_req_addr[9:2]];
    end
  end

  task automatic predict(output int k, output logic [1:0] c, output logic [7:0] cm,
                         output logic [23:0] n, output logic [31:0] a, output logic [31:0] x,
                         output string tag);
    logic [31:0] w0, w1, ta, p4;
    k = -1; tag = "R4"; c = 0; cm = 0; n = 0; a = 0; x = 0;
    while (k < 0) begin
      if (m_cnt >= m_lim) k = EV_UDC;
      else begin
        m_cnt++;
        w0 = mem[m_ptr[9:2]];
        if (w0 == 0) m_ptr += 4;
        else begin
          p4 = m_ptr + 4;
          w1 = mem[p4[9:2]];
          m_ptr += 8;
          c = w0[31:30]; cm = w0[31:24]; n = w0[23:0]; a = w1; x = w1;
          k = EV_DISP;
          if (c == 2'd0) begin
            if (w0[29]) begin a = mem[w1[9:2]]; tag = "R5"; end
            else if (w0[28]) begin
              ta = m_dsa + {{8{w1[23]}}, w1[23:0]};
              n = mem[ta[9:2]][23:0];
              ta = ta + 4;
              a = mem[ta[9:2]];
              tag = "R6";
            end
            if (w0[26:24] != m_phase) k = EV_PH;
          end
        end
      end
    end
  endtask

  task automatic wait_ev(output int got);
    got = -1;
    for (int i = 0; i < 3000 && got < 0; i++) begin
      @(negedge clk); #2;
      if (disp_valid && disp_ready) got = EV_DISP;
      else if (irq_udc) got = EV_UDC;
      else if (irq_phase) got = EV_PH;
      else if (irq_step) got = EV_STEP;
    end
  endtask

  function automatic string ev_req(int k);
    if (k == EV_UDC) return "R3";
    if (k == EV_PH) return "R7";
    if (k == EV_STEP) return "R8";
    return "R4";
  endfunction

  task automatic run_prog(int ptr, int lim, bit step, logic [2:0] ph, int dsa);
    int k, got;
    logic [1:0] c; logic [7:0] cm; logic [23:0] n; logic [31:0] a, x;
    string tag;
    bit done = 0;
    start_ptr = ptr; insn_limit = lim[15:0]; step_en = step; bus_phase = ph; dsa_base = dsa;
    m_ptr = ptr; m_cnt = 0; m_lim = lim; m_dsa = dsa; m_phase = ph;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done) begin
      predict(k, c, cm, n, a, x, tag);
      wait_ev(got);
      chk(got == k, ev_req(k), "event kind", got, k);
      if (got != k) begin
        done = 1;
        repeat (20) @(negedge clk);
      end else if (k == EV_DISP) begin
        chk(disp_class == c && disp_cmd == cm, "R4", "class/cmd", {disp_class, disp_cmd}, {c, cm});
        chk(disp_aux == x, "R4", "aux word", disp_aux, x);
        chk(disp_count == n, tag, "count", disp_count, n);
        chk(disp_addr == a, tag, "operand address", disp_addr, a);
        chk(script_ptr == m_ptr, "R1", "pointer advance", script_ptr, m_ptr);
        if (step) begin
          wait_ev(got);
          chk(got == EV_STEP, "R8", "single-step irq", got, EV_STEP);
          done = 1;
        end
      end else done = 1;
      if (done) begin
        @(negedge clk); #2;
        chk(!busy && !irq_udc && !irq_phase && !irq_step, "R11", "idle after irq",
            {busy, irq_udc, irq_phase, irq_step}, 0);
      end
    end
  endtask

  function automatic logic [31:0] bm(bit ind, bit tbl, logic [2:0] ph, logic [23:0] n);
    return {2'b00, ind, tbl, 1'b0, ph, n};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    foreach (mem[i]) mem[i] = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !rd_req_valid && !disp_valid && !irq_udc && !irq_phase && !irq_step,
        "R11", "reset state", {busy, rd_req_valid, disp_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: zero budget, immediate disconnect
    run_prog(0, 0, 0, 3'd0, 0);
    // R1 R4: two non-move instructions then budget out
    mem[0] = 32'h4A12_3456; mem[1] = 32'h0000_0100;
    mem[2] = 32'h8855_0001; mem[3] = 32'hDEAD_BEE0;
    run_prog(0, 2, 0, 3'd0, 0);
    // R2: zero word skipped, budget runs out on a zero word
    foreach (mem[i]) mem[i] = 0;
    mem[1] = 32'hC100_0007; mem[2] = 32'h0000_0040;
    run_prog(0, 3, 0, 3'd0, 0);
    // R5: both mode bits set, indirect wins
    mem[16] = bm(1, 1, 3'd2, 24'h000010); mem[17] = 32'h0000_0080; mem[32] = 32'h1234_5678;
    run_prog(64, 1, 0, 3'd2, 0);
    // R6: table-indirect with negative offset
    mem[20] = bm(0, 1, 3'd1, 24'h0); mem[21] = 32'h00FF_FFF8;
    mem[48] = 32'hAB00_0123; mem[49] = 32'h0BAD_F00D;
    run_prog(80, 1, 0, 3'd1, 200);
    // R7: phase mismatch on direct move
    mem[24] = bm(0, 0, 3'd5, 24'h20); mem[25] = 32'h0000_0300;
    run_prog(96, 4, 0, 3'd4, 0);
    // R8: single step
    run_prog(0, 8, 1, 3'd0, 0);

    // R9: stop during a long stream
    foreach (mem[i]) mem[i] = 32'h4000_0001;
    start_ptr = 0; insn_limit = 16'd200; step_en = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    stop = 1;
    @(negedge clk); stop = 0;
    begin
      bit seen_irq = 0;
      int t = 0;
      while (busy && t < 200) begin
        @(negedge clk); #2;
        if (irq_udc || irq_phase || irq_step) seen_irq = 1;
        t++;
      end
      chk(!busy, "R9", "idle after stop", busy, 0);
      chk(!seen_irq, "R9", "no irq on stop", seen_irq, 0);
      repeat (5) @(negedge clk);
      chk(!rd_req_valid && !busy, "R9", "no reads after stop", rd_req_valid, 0);
    end

    // random streams
    for (int r = 0; r < 40; r++) begin
      logic [2:0] ph;
      ph = 3'($urandom % 8);
      foreach (mem[i]) begin
        int s;
        s = int'($urandom % 10);
        if (s == 0) mem[i] = 0;
        else begin
          mem[i] = $urandom;
          if (mem[i][31:30] == 2'b00 && s < 8) mem[i][26:24] = ph;
        end
      end
      rdy_pct = 30 + int'($urandom % 70);
      run_prog(int'($urandom % 64) * 4, 1 + int'($urandom % 10), ($urandom % 5) == 0, ph,
               int'($urandom));
    end

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule